// File: doc/BRIEF.md
# Flat Page-Table Address Translator

This block maps 32-bit device virtual addresses onto physical addresses through a single table held in memory. The table has one 32-bit descriptor for every 4 KB page, so one lookup covers the full 4 GB space and no multi-level walk exists. For each accepted request the block computes where the page's descriptor sits, reads that one word over a simple memory read port, and then answers with a physical address.

A descriptor carries a physical page base in its upper twenty bits, a valid flag in bit 1 and a non-secure flag in bit 3. If the valid flag is set, the physical address is that page base combined with the in-page offset of the request. If the flag is clear, the access is steered to a protect buffer whose address software programs. The block also raises a one-cycle fault pulse and records the faulting page address.

Software writes two registers through a small write port. One holds the table base and the other holds the protect address. Only one descriptor fetch is ever in flight. A new table base that is written while a fetch is pending only applies to the next request.

Top module: `flat_xlate`

## Requirements
- R1: After reset, reqReady is 1 and memReqValid, rspValid, rspFault, faultPulse and faultVa are all 0.
- R2: One cycle after a request is accepted (reqValid and reqReady both high at a clock edge), memReqValid is 1. memReqAddr then equals the table base plus 4 times reqVa[31:12], modulo 2^32. Both signals hold steady until memReqReady is sampled high.
- R3: reqReady is 0 from the cycle after acceptance up to and including the response cycle, so at most one descriptor fetch is outstanding.
- R4: The response comes in the cycle after memRspValid is sampled high. If descriptor bit 1 is 1, then rspValid is 1, rspFault is 0, and rspPa is {descriptor[31:12], reqVa[11:0]}.
- R5: On a non-faulting response, rspNonSec equals descriptor bit 3. On a faulting response, rspNonSec is 0.
- R6: If descriptor bit 1 is 0, the response has rspFault set to 1 and rspPa set to the protect address. faultPulse is 1 in that same cycle only.
- R7: On a fault, faultVa takes the value {reqVa[31:12], 12'h000}. A non-faulting response leaves faultVa unchanged.
- R8: A table-base write made while a fetch is pending does not change that fetch's memReqAddr. The new base applies from the next request onward.
- R9: rspValid is high for exactly one cycle per request. reqReady returns to 1 in the cycle after the response.
- R10: A configuration write with cfgSel=0 loads the table base and clears its low 2 bits. A write with cfgSel=1 loads the protect address and clears its low 7 bits, which gives 128-byte alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 selects table base, 1 selects protect address |
| cfgWrData | input | 32 | Configuration write data |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Block can accept a request |
| reqVa | input | 32 | Virtual address to translate |
| memReqValid | output | 1 | Descriptor read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 32 | Descriptor address |
| memRspValid | input | 1 | Descriptor data valid |
| memRspData | input | 32 | Descriptor word |
| rspValid | output | 1 | Translation result valid (one cycle) |
| rspPa | output | 32 | Physical address or protect address |
| rspFault | output | 1 | Result is a translation fault |
| rspNonSec | output | 1 | Non-secure flag from the descriptor |
| faultPulse | output | 1 | One-cycle fault indication |
| faultVa | output | 32 | Page address of the most recent fault |

## Verification
A request is accepted at an edge, and the descriptor address appears one edge later. That address must stay unchanged through every cycle in which memReqReady is held low. The result appears exactly one edge after the descriptor word is taken, and reqReady comes back one edge after that. The updated faultVa is also visible in that same later cycle. The bench drives inputs on the falling edge and samples every output at the following falling edge, which is the point where each value is due by this count. It adds chosen stall cycles on both memory handshakes so that holding behaviour and the absence of early results are checked, not only the fastest path.

// File: rtl/flat_xlate_pkg.sv
package flat_xlate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_RESP
  } xlState_t;

  typedef struct packed {
    logic captureReq;
    logic captureDesc;
    logic respond;
  } xlStrobe_t;
endpackage

// File: rtl/flat_xlate_ctl.sv
module flat_xlate_ctl
  import flat_xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      memReqReady,
  input  logic      memRspValid,
  output logic      reqReady,
  output logic      memReqValid,
  output logic      rspValid,
  output xlStrobe_t strobe
);
  xlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (reqValid)    stateNext = ST_FETCH;
      ST_FETCH: if (memReqReady) stateNext = ST_WAIT;
      ST_WAIT:  if (memRspValid) stateNext = ST_RESP;
      ST_RESP:                   stateNext = ST_IDLE;
      default:                   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    reqReady           = (state == ST_IDLE);
    memReqValid        = (state == ST_FETCH);
    rspValid           = (state == ST_RESP);
    strobe.captureReq  = (state == ST_IDLE) && reqValid;
    strobe.captureDesc = (state == ST_WAIT) && memRspValid;
    strobe.respond     = (state == ST_RESP);
  end
endmodule

// File: rtl/flat_xlate_dp.sv
module flat_xlate_dp
  import flat_xlate_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int DESC_W     = 32,
  parameter int VALID_BIT  = 1,
  parameter int NONSEC_BIT = 3,
  parameter int PROT_ALIGN = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlStrobe_t         strobe,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic [ADDR_W-1:0] reqVa,
  input  logic [DESC_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] rspPa,
  output logic              rspFault,
  output logic              rspNonSec,
  output logic              faultPulse,
  output logic [ADDR_W-1:0] faultVa
);
  localparam int VPN_W       = ADDR_W - PAGE_SHIFT;
  localparam int ENTRY_SHIFT = $clog2(DESC_W / 8);

  logic [ADDR_W-1:0] tableBase, protAddr, baseSnap, vaReg;
  logic [ADDR_W-1:0] baseMasked, protMasked;
  logic [DESC_W-1:0] descReg;
  logic [VPN_W-1:0]  vpn;
  logic              descValid;

  // alignment of the two configuration registers
  generate
    if (ENTRY_SHIFT > 0) begin : g_baseAlign
      assign baseMasked = {cfgWrData[ADDR_W-1:ENTRY_SHIFT], {ENTRY_SHIFT{1'b0}}};
    end else begin : g_baseRaw
      assign baseMasked = cfgWrData;
    end
    if (PROT_ALIGN > 0) begin : g_protAlign
      assign protMasked = {cfgWrData[ADDR_W-1:PROT_ALIGN], {PROT_ALIGN{1'b0}}};
    end else begin : g_protRaw
      assign protMasked = cfgWrData;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tableBase <= '0;
      protAddr  <= '0;
    end else if (cfgWrEn) begin
      if (cfgSel) protAddr  <= protMasked;
      else        tableBase <= baseMasked;
    end
  end

  // request capture: base is snapshotted so later writes hit the next request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg    <= '0;
      baseSnap <= '0;
    end else if (strobe.captureReq) begin
      vaReg    <= reqVa;
      baseSnap <= tableBase;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   descReg <= '0;
    else if (strobe.captureDesc) descReg <= memRspData;
  end

  assign vpn        = vaReg[ADDR_W-1:PAGE_SHIFT];
  assign memReqAddr = baseSnap + (ADDR_W'(vpn) << ENTRY_SHIFT);
  assign descValid  = descReg[VALID_BIT];

  always_comb begin
    rspFault   = strobe.respond && !descValid;
    faultPulse = rspFault;
    rspNonSec  = strobe.respond && descValid && descReg[NONSEC_BIT];
    if (descValid) rspPa = {descReg[ADDR_W-1:PAGE_SHIFT], vaReg[PAGE_SHIFT-1:0]};
    else           rspPa = protAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         faultVa <= '0;
    else if (rspFault) faultVa <= {vpn, {PAGE_SHIFT{1'b0}}};
  end
endmodule

// File: rtl/flat_xlate.sv
module flat_xlate
  import flat_xlate_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int DESC_W     = 32,
  parameter int VALID_BIT  = 1,
  parameter int NONSEC_BIT = 3,
  parameter int PROT_ALIGN = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVa,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [DESC_W-1:0] memRspData,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspPa,
  output logic              rspFault,
  output logic              rspNonSec,
  output logic              faultPulse,
  output logic [ADDR_W-1:0] faultVa
);
  xlStrobe_t strobe;

  flat_xlate_ctl u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .reqReady(reqReady), .memReqValid(memReqValid),
    .rspValid(rspValid), .strobe(strobe)
  );

  flat_xlate_dp #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .DESC_W(DESC_W),
    .VALID_BIT(VALID_BIT), .NONSEC_BIT(NONSEC_BIT), .PROT_ALIGN(PROT_ALIGN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .reqVa(reqVa), .memRspData(memRspData),
    .memReqAddr(memReqAddr), .rspPa(rspPa), .rspFault(rspFault),
    .rspNonSec(rspNonSec), .faultPulse(faultPulse), .faultVa(faultVa)
  );
endmodule

// File: rtl/flat_xlate_chk.sv
module flat_xlate_chk #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int PROT_ALIGN = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqVa,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              rspValid,
  input logic [ADDR_W-1:0] rspPa,
  input logic              rspFault,
  input logic              faultPulse,
  input logic [ADDR_W-1:0] faultVa
);
  localparam logic [ADDR_W-1:0] OFF_MASK  = ADDR_W'((64'd1 << PAGE_SHIFT) - 1);
  localparam logic [ADDR_W-1:0] PROT_MASK = ADDR_W'((64'd1 << PROT_ALIGN) - 1);

  logic [ADDR_W-1:0] vaSeen;
  always_ff @(posedge clk) begin
    if (!rstN)                     vaSeen <= '0;
    else if (reqValid && reqReady) vaSeen <= reqVa;
  end

  // R2: a stalled fetch keeps its request and address
  p_hold_fetch_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  // R3: no acceptance while a fetch or response is pending
  p_single_fetch_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReqValid && !rspValid);

  // R4: in-page offset passes through unchanged
  p_offset_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspFault |-> (rspPa & OFF_MASK) == (vaSeen & OFF_MASK));

  // R6: fault pulse only with a faulting response
  p_fault_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> rspValid && rspFault);

  // R7: recorded fault address is page aligned
  p_fault_va_r7: assert property (@(posedge clk) disable iff (!rstN)
    (faultVa & OFF_MASK) == '0);

  // R9: response lasts one cycle, then ready again
  p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid && reqReady);

  // R10: redirect address honours protect alignment
  p_prot_align_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> (rspPa & PROT_MASK) == '0);
endmodule

bind flat_xlate flat_xlate_chk #(
  .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .PROT_ALIGN(PROT_ALIGN)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqVa(reqVa),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
  .rspValid(rspValid), .rspPa(rspPa), .rspFault(rspFault),
  .faultPulse(faultPulse), .faultVa(faultVa)
);

// File: tb/sim_flat_xlate.sv
module sim_flat_xlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0, cfgSel = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVa = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        rspValid, rspFault, rspNonSec, faultPulse;
  logic [31:0] rspPa, faultVa;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] baseExp = '0, protExp = '0, fvaExp = '0;

  always #10 clk = ~clk;

  flat_xlate u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .reqReady(reqReady), .reqVa(reqVa),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .rspValid(rspValid),
    .rspPa(rspPa), .rspFault(rspFault), .rspNonSec(rspNonSec),
    .faultPulse(faultPulse), .faultVa(faultVa)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic cfgWrite(input logic sel, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (sel) protExp = data & 32'hFFFF_FF80;
    else     baseExp = data & 32'hFFFF_FFFC;
  endtask

  task automatic xlate(input logic [31:0] va, input logic [31:0] desc,
                       input int readyDelay, input int rspDelay,
                       input logic doBase, input logic [31:0] newBase);
    logic [31:0] expAddr, expPa;
    logic        expFault, expNs;
    expAddr  = baseExp + {va[31:12], 2'b00};
    expFault = !desc[1];
    expPa    = expFault ? protExp : {desc[31:12], va[11:0]};
    expNs    = !expFault && desc[3];
    @(negedge clk);
    chk("R3 ready idle", {31'd0, reqReady}, 32'd1);
    reqValid = 1'b1; reqVa = va;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R2 fetch valid", {31'd0, memReqValid}, 32'd1);
    chk("R2 entry addr", memReqAddr, expAddr);
    chk("R3 busy", {31'd0, reqReady}, 32'd0);
    if (doBase) begin
      cfgWrEn = 1'b1; cfgSel = 1'b0; cfgWrData = newBase;
      baseExp = newBase & 32'hFFFF_FFFC;
    end
    memReqReady = (readyDelay == 0);
    for (int i = 0; i < readyDelay; i++) begin
      @(negedge clk);
      cfgWrEn = 1'b0;
      chk("R2 hold valid", {31'd0, memReqValid}, 32'd1);
      chk("R8 hold addr", memReqAddr, expAddr);
      if (i == readyDelay - 1) memReqReady = 1'b1;
    end
    @(negedge clk);
    cfgWrEn = 1'b0; memReqReady = 1'b0;
    chk("R2 fetch done", {31'd0, memReqValid}, 32'd0);
    for (int i = 0; i < rspDelay; i++) begin
      @(negedge clk);
      chk("R4 no early rsp", {31'd0, rspValid}, 32'd0);
    end
    memRspValid = 1'b1; memRspData = desc;
    @(negedge clk);
    memRspValid = 1'b0; memRspData = '0;
    chk("R4 rsp valid", {31'd0, rspValid}, 32'd1);
    chk("R4 R6 rsp pa", rspPa, expPa);
    chk("R6 fault flag", {31'd0, rspFault}, {31'd0, expFault});
    chk("R6 fault pulse", {31'd0, faultPulse}, {31'd0, expFault});
    chk("R5 nonsec", {31'd0, rspNonSec}, {31'd0, expNs});
    chk("R3 busy in rsp", {31'd0, reqReady}, 32'd0);
    if (expFault) fvaExp = {va[31:12], 12'h000};
    @(negedge clk);
    chk("R9 rsp one cycle", {31'd0, rspValid}, 32'd0);
    chk("R6 pulse one cycle", {31'd0, faultPulse}, 32'd0);
    chk("R9 ready back", {31'd0, reqReady}, 32'd1);
    chk("R7 fault va", faultVa, fvaExp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 reqReady", {31'd0, reqReady}, 32'd1);
    chk("R1 memReqValid", {31'd0, memReqValid}, 32'd0);
    chk("R1 rspValid", {31'd0, rspValid}, 32'd0);
    chk("R1 rspFault", {31'd0, rspFault}, 32'd0);
    chk("R1 faultPulse", {31'd0, faultPulse}, 32'd0);
    chk("R1 faultVa", faultVa, 32'd0);
    // R10: low bits of both registers dropped
    cfgWrite(1'b0, 32'h8000_0003);
    cfgWrite(1'b1, 32'h1234_56FF);
    // R4 R5: valid, non-secure, no stalls
    xlate(32'h0000_5ABC, 32'hCAFE_F00A, 0, 0, 1'b0, '0);
    // R2 R4: top page, stalls on both handshakes, secure
    xlate(32'hFFFF_F123, 32'h0004_2002, 3, 2, 1'b0, '0);
    // R6 R7 R10: invalid descriptor redirects to aligned protect address
    xlate(32'h1234_5678, 32'hABCD_E008, 1, 1, 1'b0, '0);
    // R8: base rewritten while fetch pending; R7 faultVa retained
    xlate(32'h0000_1000, 32'h0000_3002, 2, 0, 1'b1, 32'h0010_0001);
    xlate(32'h0000_2010, 32'h7777_700A, 0, 1, 1'b0, '0);
    // R2: entry address wraps modulo 2^32
    cfgWrite(1'b0, 32'hFFC0_0004);
    xlate(32'hFFFF_FFFF, 32'h0000_0000, 0, 0, 1'b0, '0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule